// File: doc/BRIEF.md
# Power Mode Sequencer

This block moves a microcontroller between four operating modes: Active, Power Save, Idle and Halt. Software programs a five-bit control register. The CPU supplies a strobe each time it executes its wait instruction. A set of wake sources plus a non-maskable source feed a latch that pulls the device back to Active. In return the block drives three outputs: the current mode, the CPU clock selection (high-frequency or slow clock) and the enable of the high-frequency oscillator.

Power Save can be entered in two ways. In immediate entry, the move starts as soon as software writes the request. In deferred entry, the move waits for the next wait-instruction strobe. Idle and Halt are always deferred. Entry to Power Save needs the slow clock to be stable. That stability is synchronised into the block and can be read back as a status bit. A request made before the slow clock is stable is held until it becomes stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in Active mode. The mode encoding is 0 = Active, 1 = Power Save, 2 = Idle, 3 = Halt. The control readback is 0, `clk_sel` is 0, `hf_osc_en` is 1 and `wake_pending` is 0.
- R2: The control bit positions are [0] save request, [1] defer-to-wait, [2] idle request, [3] halt request and [4] high-clock-off. In immediate mode (bit 1 clear), writing bit 0 = 1 while Active and with the slow clock stable gives mode 1 one clock after the write edge. Bit 0 reads 0 until that edge and 1 from it on. `clk_sel` is 1 whenever the mode is not Active.
- R3: In deferred mode (bit 1 set), a written save request reads back as 1 from the write edge on. The mode stays Active until a wait strobe arrives. Power Save is entered one clock after the edge that samples the strobe.
- R4: Idle and Halt are entered at the edge that samples a wait strobe, and only when the defer bit is set and the mode is Active or Power Save. A wait strobe with the defer bit clear, or one that arrives while in Idle or Halt, changes nothing.
- R5: When several request bits are set as the wait strobe arrives, Halt wins over Idle, and Idle wins over Power Save.
- R6: A Power Save request made while the synchronised slow-clock status is 0 is held. The mode changes one clock after the status becomes 1.
- R7: `hf_osc_en` is 1 in Active and 0 in Halt. In Power Save or Idle it equals the inverse of bit 4, but it follows the bit only one clock after the mode was entered or the bit was written.
- R8: A pulse on any wake source or on `nmi` sets `wake_pending` at the sampling edge. It stays set until `irq_ack`. A new event in the same cycle as `irq_ack` wins over the acknowledge.
- R9: With `wake_pending` set and the mode not Active, the next edge returns the block to Active. That edge clears bits 0, 2 and 3 and keeps bits 1 and 4.
- R10: `stat_slow_ok` follows `slow_stable` after `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Control register write data |
| ctrl_rd | output | 5 | Control register readback |
| stat_slow_ok | output | 1 | Synchronised slow-clock-stable status |
| wait_stb | input | 1 | CPU wait-instruction strobe |
| wake_src | input | NUM_WAKE | Maskable wake event pulses |
| nmi | input | 1 | Non-maskable wake event pulse |
| irq_ack | input | 1 | Interrupt acknowledge, clears the wake latch |
| slow_stable | input | 1 | Slow oscillator stable, asynchronous |
| mode | output | 2 | Current mode (0 Active, 1 Save, 2 Idle, 3 Halt) |
| clk_sel | output | 1 | CPU clock select, 1 = slow clock |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| wake_pending | output | 1 | Latched wake event |

## Verification
The bench sweeps all eight combinations of the save, idle and halt request bits with the defer bit set and a following wait strobe. This separates the priority order from the plain entry paths. Immediate and deferred Power Save requests are each tried with the slow clock stable and with it not yet stable. The first pair tells where the status bit sets, and the second tells whether a request is dropped or held. The oscillator enable is watched across entry to Save, Idle and Halt with the high-clock-off bit both set and clear, and across a wake return. These runs tell forced states apart from the delayed turn-off. Wake events from a maskable source and from the non-maskable source are followed by acknowledges, including an acknowledge in the same cycle as a new event.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_SAVE   = 2'd1,
        PM_IDLE   = 2'd2,
        PM_HALT   = 2'd3
    } pm_mode_e;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic hf_off;
        logic halt;
        logic idle;
        logic defer;
        logic save;
    } pm_ctrl_t;

    // Mode chosen by a wait strobe: halt over idle over save.
    function automatic pm_mode_e wait_target(input pm_ctrl_t c, input pm_mode_e cur);
        pm_mode_e t;
        t = cur;
        if (c.halt)
            t = PM_HALT;
        else if (c.idle)
            t = PM_IDLE;
        else if (c.save && cur == PM_ACTIVE)
            t = PM_SAVE;
        return t;
    endfunction

    function automatic logic is_low_power(input pm_mode_e m);
        return m != PM_ACTIVE;
    endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_wake_latch.sv
module pmc_wake_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  logic               nmi,
    input  logic               ack,
    output logic               pending
);
    localparam int TOTAL = NUM_SRC + 1;

    logic [TOTAL-1:0] ev;
    logic [TOTAL-1:0] held;

    assign ev = {nmi, src};

    generate
        for (genvar i = 0; i < TOTAL; i++) begin : g_lat
            always_ff @(posedge clk) begin
                if (rst)        held[i] <= 1'b0;
                else if (ev[i]) held[i] <= 1'b1;
                else if (ack)   held[i] <= 1'b0;
            end
        end
    endgenerate

    assign pending = |held;
endmodule

// File: rtl/pmc_hf_gate.sv
module pmc_hf_gate
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pm_mode_e mode,
    input  logic     hf_off,
    output logic     hf_en
);
    logic allow_q;

    // Follows the register one clock late so the oscillator stops after entry.
    always_ff @(posedge clk) begin
        if (rst)
            allow_q <= 1'b1;
        else if (mode == PM_SAVE || mode == PM_IDLE)
            allow_q <= ~hf_off;
        else
            allow_q <= 1'b1;
    end

    always_comb begin
        unique case (mode)
            PM_ACTIVE: hf_en = 1'b1;
            PM_HALT:   hf_en = 1'b0;
            default:   hf_en = allow_q;
        endcase
    end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    input  logic              wait_stb,
    input  logic              wake,
    input  logic              slow_ok,
    output pm_mode_e          mode,
    output pm_ctrl_t          ctrl
);
    pm_mode_e mode_q;
    pm_ctrl_t ctrl_q;
    pm_ctrl_t wr_c;
    logic     pend_q;
    logic     wait_ok;
    pm_mode_e wait_to;

    assign wr_c    = pm_ctrl_t'(reg_wdata);
    assign wait_ok = wait_stb && ctrl_q.defer &&
                     (mode_q == PM_ACTIVE || mode_q == PM_SAVE);
    assign wait_to = wait_target(ctrl_q, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_ACTIVE;
            ctrl_q <= '0;
            pend_q <= 1'b0;
        end else if (wake && is_low_power(mode_q)) begin
            mode_q      <= PM_ACTIVE;
            ctrl_q.save <= 1'b0;
            ctrl_q.idle <= 1'b0;
            ctrl_q.halt <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            if (reg_wr) begin
                ctrl_q.defer  <= wr_c.defer;
                ctrl_q.idle   <= wr_c.idle;
                ctrl_q.halt   <= wr_c.halt;
                ctrl_q.hf_off <= wr_c.hf_off;
                if (wr_c.save) begin
                    if (wr_c.defer)
                        ctrl_q.save <= 1'b1;
                    else if (mode_q == PM_ACTIVE)
                        pend_q <= 1'b1;
                end
            end
            if (pend_q && slow_ok && mode_q == PM_ACTIVE) begin
                mode_q      <= PM_SAVE;
                ctrl_q.save <= 1'b1;
                pend_q      <= 1'b0;
            end
            if (wait_ok) begin
                if (wait_to == PM_HALT || wait_to == PM_IDLE) begin
                    mode_q <= wait_to;
                    pend_q <= 1'b0;
                end else if (wait_to == PM_SAVE) begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

    assign mode = mode_q;
    assign ctrl = ctrl_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_WAKE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [CTRL_W-1:0]   reg_wdata,
    output logic [CTRL_W-1:0]   ctrl_rd,
    output logic                stat_slow_ok,
    input  logic                wait_stb,
    input  logic [NUM_WAKE-1:0] wake_src,
    input  logic                nmi,
    input  logic                irq_ack,
    input  logic                slow_stable,
    output logic [1:0]          mode,
    output logic                clk_sel,
    output logic                hf_osc_en,
    output logic                wake_pending
);
    logic     slow_ok;
    logic     wake_q;
    pm_mode_e mode_s;
    pm_ctrl_t ctrl_s;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(slow_stable), .q(slow_ok)
    );

    pmc_wake_latch #(.NUM_SRC(NUM_WAKE)) u_wake (
        .clk(clk), .rst(rst), .src(wake_src), .nmi(nmi),
        .ack(irq_ack), .pending(wake_q)
    );

    pmc_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .wait_stb(wait_stb), .wake(wake_q), .slow_ok(slow_ok),
        .mode(mode_s), .ctrl(ctrl_s)
    );

    pmc_hf_gate u_hf (
        .clk(clk), .rst(rst), .mode(mode_s), .hf_off(ctrl_s.hf_off),
        .hf_en(hf_osc_en)
    );

    assign ctrl_rd      = ctrl_s;
    assign stat_slow_ok = slow_ok;
    assign mode         = mode_s;
    assign clk_sel      = is_low_power(mode_s);
    assign wake_pending = wake_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       hf_osc_en,
    input logic       wake_pending,
    input logic       irq_ack,
    input logic       stat_slow_ok
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    a_r1_reset_active: assert property (@(posedge clk) rst |=> mode == 2'd0);
    // R7
    a_r7_active_hf_on: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd0 |-> hf_osc_en);
    // R7
    a_r7_halt_hf_off: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd3 |-> !hf_osc_en);
    // R8
    a_r8_wake_held: assert property (@(posedge clk) disable iff (rst)
        (wake_pending && !irq_ack) |=> wake_pending);
    // R9
    a_r9_wake_return: assert property (@(posedge clk) disable iff (rst)
        (wake_pending && mode != 2'd0) |=> mode == 2'd0);
    // R4
    a_r4_deep_entry_src: assert property (@(posedge clk) disable iff (rst)
        (past_ok && mode[1] && mode != $past(mode)) |-> !$past(mode[1]));
    // R6
    a_r6_save_needs_slow: assert property (@(posedge clk) disable iff (rst)
        (past_ok && mode == 2'd1 && $past(mode) == 2'd0) |-> $past(stat_slow_ok));
endmodule

bind pwr_mode_ctrl pmc_checker u_pmc_checker (
    .clk(clk), .rst(rst), .mode(mode), .hf_osc_en(hf_osc_en),
    .wake_pending(wake_pending), .irq_ack(irq_ack), .stat_slow_ok(stat_slow_ok)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst, reg_wr, wait_stb, nmi, irq_ack, slow_stable;
    logic [4:0]    reg_wdata;
    logic [NW-1:0] wake_src;
    logic [4:0]    ctrl_rd;
    logic          stat_slow_ok, clk_sel, hf_osc_en, wake_pending;
    logic [1:0]    mode;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.NUM_WAKE(NW), .SYNC_STAGES(2)) u_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_rd(ctrl_rd), .stat_slow_ok(stat_slow_ok), .wait_stb(wait_stb),
        .wake_src(wake_src), .nmi(nmi), .irq_ack(irq_ack),
        .slow_stable(slow_stable), .mode(mode), .clk_sel(clk_sel),
        .hf_osc_en(hf_osc_en), .wake_pending(wake_pending)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(input logic [4:0] d);
        reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_wait();
        wait_stb = 1'b1; tick(); wait_stb = 1'b0;
    endtask

    task automatic pulse_nmi_ack();
        nmi = 1'b1; tick(); nmi = 1'b0;
        tick();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(2); rst = 1'b0; tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_wdata = 0; wait_stb = 0; nmi = 0;
        irq_ack = 0; slow_stable = 0; wake_src = '0;
        tick(3); rst = 1'b0; tick();

        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 ctrl", ctrl_rd, 0);
        check("R1 clk_sel", clk_sel, 0);
        check("R1 hf_en", hf_osc_en, 1);
        check("R1 wake", wake_pending, 0);
        check("R10 stat low", stat_slow_ok, 0);

        // R6 immediate request held while slow clock unstable
        write(5'b00001);
        tick(5);
        check("R6 held mode", mode, 0);
        check("R2 save bit before entry", ctrl_rd[0], 0);
        slow_stable = 1'b1;
        tick(2);
        check("R10 stat after sync", stat_slow_ok, 1);
        check("R6 not yet", mode, 0);
        tick();
        check("R6 entered", mode, 1);
        check("R2 save bit after entry", ctrl_rd[0], 1);
        check("R2 clk_sel slow", clk_sel, 1);

        // R8 wake from a maskable source, R9 return
        wake_src[2] = 1'b1; tick(); wake_src = '0;
        check("R8 latched", wake_pending, 1);
        check("R9 not yet", mode, 1);
        tick();
        check("R9 active", mode, 0);
        check("R9 save cleared", ctrl_rd[0], 0);
        check("R9 clk_sel", clk_sel, 0);
        check("R8 still held", wake_pending, 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check("R8 ack clears", wake_pending, 0);
        nmi = 1'b1; irq_ack = 1'b1; tick(); nmi = 1'b0; irq_ack = 1'b0;
        check("R8 event beats ack", wake_pending, 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;

        // R2 immediate entry with stable slow clock
        write(5'b00001);
        check("R2 mode at write", mode, 0);
        check("R2 bit at write", ctrl_rd[0], 0);
        tick();
        check("R2 mode", mode, 1);
        pulse_nmi_ack();
        check("R9 back", mode, 0);

        // R3 deferred entry
        write(5'b00011);
        check("R3 bit at write", ctrl_rd[0], 1);
        tick(3);
        check("R3 waits", mode, 0);
        pulse_wait();
        check("R3 not yet", mode, 0);
        tick();
        check("R3 entered", mode, 1);
        check("R7 save hf on", hf_osc_en, 1);
        write(5'b10011);
        check("R7 hf right after write", hf_osc_en, 1);
        tick();
        check("R7 hf off in save", hf_osc_en, 0);
        nmi = 1'b1; tick(); nmi = 1'b0; tick();
        check("R9 hf forced on", hf_osc_en, 1);
        check("R9 kept bits", ctrl_rd, 5'b10010);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;

        // R7 idle with high clock off, R4 wait ignored in idle
        write(5'b10110);
        pulse_wait();
        check("R4 idle", mode, 2);
        check("R7 idle first cycle", hf_osc_en, 1);
        tick();
        check("R7 idle hf off", hf_osc_en, 0);
        pulse_wait();
        tick();
        check("R4 wait in idle ignored", mode, 2);
        pulse_nmi_ack();

        // R4 halt
        write(5'b01010);
        pulse_wait();
        check("R4 halt", mode, 3);
        check("R7 halt hf off", hf_osc_en, 0);
        pulse_nmi_ack();
        check("R9 from halt", mode, 0);

        // R4 without defer the wait is ignored
        write(5'b01000);
        pulse_wait();
        tick();
        check("R4 no defer", mode, 0);

        // R5 priority sweep over request bits
        for (int k = 0; k < 8; k++) begin
            int expm;
            do_reset();
            write({1'b0, k[2], k[1], 1'b1, k[0]});
            pulse_wait();
            tick();
            expm = k[2] ? 3 : (k[1] ? 2 : (k[0] ? 1 : 0));
            check($sformatf("R5 combo %0d", k), mode, expm);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule